// File: doc/BRIEF.md
# Soft-Switch Shadow Register

This block sits beside a host bus with 8-bit data and 16-bit addresses and watches every cycle, read or write, without ever driving the bus. When a cycle lands in the 128-byte I/O window at 0xC000–0xC07F, the low seven address bits pick a display or memory-mapping switch. The block then updates its own copy of that switch, so that a video generator or a memory mirror nearby can follow the host's mode settings without asking the host.

Switches come in two kinds. Paired switches are cleared by one offset and set by its neighbour. Field registers load all or part of the data byte. Each switch has its own gate. Some react to any access. Others react only to writes, and only while a machine-class flag from a neighbouring detector is raised. There are two such flags: the enhanced-register class and the extended-register class. All outputs are registered. A snooped cycle shows at the outputs right after the clock edge that samples it.

Top module: `sswitch_shadow`

## Requirements
- R1: Synchronous active-high reset clears every switch bit and all four field registers to zero.
- R2: A cycle changes nothing unless address bits 15..7 match those of the window base (0xC000). For example, 0xC151 and 0x4051 are both ignored.
- R3: Offsets 0x50/0x51, 0x52/0x53, 0x54/0x55 and 0x56/0x57 clear/set, in that order, text mode, mixed mode, page-2 select and hi-res mode. They act on reads and on writes, with no class flag needed.
- R4: Offsets 0x00/0x01 (80-store), 0x04/0x05 (aux write), 0x08/0x09 (aux zero page), 0x0C/0x0D (80-column) and 0x0E/0x0F (alternate charset) clear/set their bit. They act only on a write and only while at least one class flag is high. A read of any of these offsets leaves all five bits unchanged.
- R5: Offset 0x5E sets and 0x5F clears the double-low-res bit, on a read or a write, while at least one class flag is high.
- R6: Offset 0x7E sets and 0x7F clears the I/O-disable bit, only on a write and only while the enhanced flag is high.
- R7: A write to offset 0x21 loads the monochrome bit from data bit 7, while at least one class flag is high.
- R8: A write to offset 0x22 with the extended flag high loads the whole data byte into the text/background colour register.
- R9: A write to offset 0x34 with the extended flag high loads data bits 3..0 into the border colour register.
- R10: With the extended flag high, a write to 0x29 loads data bits 7..0 into the new-video control field, and a write to 0x35 loads data bits 6..0 into the shadow control field. Every other switch keeps its value.
- R11: A cycle is seen only when the strobe is high. The read/write flag (1 = read, 0 = write) is sampled on the same edge. Offsets not named above have no effect.
- R12: An accepted cycle's effect is visible at the outputs right after the clock edge that samples its strobe, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | One pulse per host bus cycle |
| bus_addr | input | 16 | Host address |
| bus_data | input | 8 | Host data byte |
| bus_rw | input | 1 | 1 = read, 0 = write |
| cls_enh | input | 1 | Enhanced-register machine class |
| cls_ext | input | 1 | Extended-register machine class |
| text_mode | output | 1 | Text mode switch |
| mixed_mode | output | 1 | Mixed mode switch |
| page2_sel | output | 1 | Page-2 select |
| hires_mode | output | 1 | Hi-res mode switch |
| store80 | output | 1 | 80-store switch |
| aux_wr | output | 1 | Aux write switch |
| aux_zp | output | 1 | Aux zero page switch |
| col80 | output | 1 | 80-column switch |
| alt_charset | output | 1 | Alternate charset switch |
| dbl_lores | output | 1 | Double-low-res switch |
| io_disable | output | 1 | I/O-disable switch |
| mono_mode | output | 1 | Monochrome switch |
| nvid_ctl | output | 8 | New-video control field |
| shadow_ctl | output | 7 | Shadow control field |
| tb_colour | output | 8 | Text/background colour |
| border_colour | output | 4 | Border colour |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the window at 0xC000, an 8-bit new-video field, a 7-bit shadow field and a 4-bit border. With these values every listed offset can be reached, along with aliases outside the window on both sides. The bench walks each switch through its gate combinations: read against write, no flag, the enhanced flag alone and the extended flag alone. After each sampled cycle it compares the full output vector, which also shows that untouched switches keep their values.

// File: rtl/sss_pkg.sv
package sss_pkg;

  localparam int WIN_BITS = 7;
  localparam int NSW      = 12;

  localparam logic [3:0] IX_TEXT    = 4'd0;
  localparam logic [3:0] IX_MIXED   = 4'd1;
  localparam logic [3:0] IX_PAGE2   = 4'd2;
  localparam logic [3:0] IX_HIRES   = 4'd3;
  localparam logic [3:0] IX_STORE80 = 4'd4;
  localparam logic [3:0] IX_AUXWR   = 4'd5;
  localparam logic [3:0] IX_AUXZP   = 4'd6;
  localparam logic [3:0] IX_COL80   = 4'd7;
  localparam logic [3:0] IX_ALTCHR  = 4'd8;
  localparam logic [3:0] IX_DLORES  = 4'd9;
  localparam logic [3:0] IX_IODIS   = 4'd10;
  localparam logic [3:0] IX_MONO    = 4'd11;

  // gating class of a paired switch
  typedef enum logic [1:0] {
    ACC_ANY,         // any access, no class needed
    ACC_ANY_EITHER,  // any access, either class flag
    ACC_WR_EITHER,   // write only, either class flag
    ACC_WR_ENH       // write only, enhanced class flag
  } acc_e;

  typedef struct packed {
    logic [WIN_BITS-1:0] base;      // even offset of the pair
    logic [3:0]          idx;       // switch bit index
    acc_e                cls;
    logic                odd_sets;  // 1: odd offset sets, 0: even offset sets
  } pair_t;

  localparam int NPAIR = 11;

  localparam pair_t PAIR_TBL [NPAIR] = '{
    '{7'h50, IX_TEXT,    ACC_ANY,        1'b1},
    '{7'h52, IX_MIXED,   ACC_ANY,        1'b1},
    '{7'h54, IX_PAGE2,   ACC_ANY,        1'b1},
    '{7'h56, IX_HIRES,   ACC_ANY,        1'b1},
    '{7'h00, IX_STORE80, ACC_WR_EITHER,  1'b1},
    '{7'h04, IX_AUXWR,   ACC_WR_EITHER,  1'b1},
    '{7'h08, IX_AUXZP,   ACC_WR_EITHER,  1'b1},
    '{7'h0C, IX_COL80,   ACC_WR_EITHER,  1'b1},
    '{7'h0E, IX_ALTCHR,  ACC_WR_EITHER,  1'b1},
    '{7'h5E, IX_DLORES,  ACC_ANY_EITHER, 1'b0},
    '{7'h7E, IX_IODIS,   ACC_WR_ENH,     1'b0}
  };

  localparam logic [WIN_BITS-1:0] OFF_MONO   = 7'h21;
  localparam logic [WIN_BITS-1:0] OFF_TBCOL  = 7'h22;
  localparam logic [WIN_BITS-1:0] OFF_NVID   = 7'h29;
  localparam logic [WIN_BITS-1:0] OFF_BORDER = 7'h34;
  localparam logic [WIN_BITS-1:0] OFF_SHADOW = 7'h35;

  typedef struct packed {
    logic [NSW-1:0] set;
    logic [NSW-1:0] clr;
    logic           ld_tb;
    logic           ld_bd;
    logic           ld_nvid;
    logic           ld_shad;
  } cmd_t;

endpackage

// File: rtl/sss_decode.sv
module sss_decode
  import sss_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hC000
) (
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              enh,
  input  logic              ext,
  input  logic              data7,
  output cmd_t              cmd
);

  localparam int HI_W = ADDR_W - WIN_BITS;
  localparam logic [HI_W-1:0] WTAG = IO_BASE[ADDR_W-1:WIN_BITS];

  logic                hit;
  logic                wr;
  logic                either;
  logic [WIN_BITS-1:0] off;

  assign hit    = stb && (addr[ADDR_W-1:WIN_BITS] == WTAG);
  assign wr     = !rw;
  assign either = enh | ext;
  assign off    = addr[WIN_BITS-1:0];

  function automatic logic gate_ok(acc_e c, logic w, logic e, logic n);
    case (c)
      ACC_ANY:        gate_ok = 1'b1;
      ACC_ANY_EITHER: gate_ok = e;
      ACC_WR_EITHER:  gate_ok = w && e;
      default:        gate_ok = w && n;
    endcase
  endfunction

  always_comb begin
    cmd = '0;
    for (int i = 0; i < NPAIR; i++) begin
      if (hit && off[WIN_BITS-1:1] == PAIR_TBL[i].base[WIN_BITS-1:1]
          && gate_ok(PAIR_TBL[i].cls, wr, either, enh)) begin
        if (off[0] == PAIR_TBL[i].odd_sets) cmd.set[PAIR_TBL[i].idx] = 1'b1;
        else                                cmd.clr[PAIR_TBL[i].idx] = 1'b1;
      end
    end
    if (hit && wr && either && off == OFF_MONO) begin
      if (data7) cmd.set[IX_MONO] = 1'b1;
      else       cmd.clr[IX_MONO] = 1'b1;
    end
    cmd.ld_tb   = hit && wr && ext && (off == OFF_TBCOL);
    cmd.ld_bd   = hit && wr && ext && (off == OFF_BORDER);
    cmd.ld_nvid = hit && wr && ext && (off == OFF_NVID);
    cmd.ld_shad = hit && wr && ext && (off == OFF_SHADOW);
  end

endmodule

// File: rtl/sss_swreg.sv
module sss_swreg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q[b] <= 1'b0;
      else if (set_i[b]) q[b] <= 1'b1;
      else if (clr_i[b]) q[b] <= 1'b0;
    end
  end

  // R3
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i & clr_i) == '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

endmodule

// File: rtl/sss_fieldreg.sv
module sss_fieldreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  // R10
  hold_unless_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));

endmodule

// File: rtl/sswitch_shadow.sv
module sswitch_shadow
  import sss_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'hC000,
  parameter int                NVID_W   = 8,
  parameter int                SHAD_W   = 7,
  parameter int                BORDER_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_stb,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_data,
  input  logic                bus_rw,
  input  logic                cls_enh,
  input  logic                cls_ext,
  output logic                text_mode,
  output logic                mixed_mode,
  output logic                page2_sel,
  output logic                hires_mode,
  output logic                store80,
  output logic                aux_wr,
  output logic                aux_zp,
  output logic                col80,
  output logic                alt_charset,
  output logic                dbl_lores,
  output logic                io_disable,
  output logic                mono_mode,
  output logic [NVID_W-1:0]   nvid_ctl,
  output logic [SHAD_W-1:0]   shadow_ctl,
  output logic [DATA_W-1:0]   tb_colour,
  output logic [BORDER_W-1:0] border_colour
);

  localparam int HI_W = ADDR_W - WIN_BITS;
  localparam logic [HI_W-1:0] WTAG = IO_BASE[ADDR_W-1:WIN_BITS];
  localparam int OBS_W = NSW + NVID_W + SHAD_W + DATA_W + BORDER_W;

  cmd_t           cmd;
  logic [NSW-1:0] sw_q;

  sss_decode #(
    .ADDR_W (ADDR_W),
    .IO_BASE(IO_BASE)
  ) u_decode (
    .stb  (bus_stb),
    .addr (bus_addr),
    .rw   (bus_rw),
    .enh  (cls_enh),
    .ext  (cls_ext),
    .data7(bus_data[DATA_W-1]),
    .cmd  (cmd)
  );

  sss_swreg #(.N(NSW)) u_swreg (
    .clk  (clk),
    .rst  (rst),
    .set_i(cmd.set),
    .clr_i(cmd.clr),
    .q    (sw_q)
  );

  sss_fieldreg #(.W(NVID_W)) u_nvid (
    .clk(clk), .rst(rst), .ld(cmd.ld_nvid),
    .d(bus_data[NVID_W-1:0]), .q(nvid_ctl)
  );

  sss_fieldreg #(.W(SHAD_W)) u_shad (
    .clk(clk), .rst(rst), .ld(cmd.ld_shad),
    .d(bus_data[SHAD_W-1:0]), .q(shadow_ctl)
  );

  sss_fieldreg #(.W(DATA_W)) u_tbcol (
    .clk(clk), .rst(rst), .ld(cmd.ld_tb),
    .d(bus_data), .q(tb_colour)
  );

  sss_fieldreg #(.W(BORDER_W)) u_border (
    .clk(clk), .rst(rst), .ld(cmd.ld_bd),
    .d(bus_data[BORDER_W-1:0]), .q(border_colour)
  );

  assign text_mode   = sw_q[IX_TEXT];
  assign mixed_mode  = sw_q[IX_MIXED];
  assign page2_sel   = sw_q[IX_PAGE2];
  assign hires_mode  = sw_q[IX_HIRES];
  assign store80     = sw_q[IX_STORE80];
  assign aux_wr      = sw_q[IX_AUXWR];
  assign aux_zp      = sw_q[IX_AUXZP];
  assign col80       = sw_q[IX_COL80];
  assign alt_charset = sw_q[IX_ALTCHR];
  assign dbl_lores   = sw_q[IX_DLORES];
  assign io_disable  = sw_q[IX_IODIS];
  assign mono_mode   = sw_q[IX_MONO];

  logic [OBS_W-1:0] obs_all;
  assign obs_all = {sw_q, nvid_ctl, shadow_ctl, tb_colour, border_colour};

  // R2
  outside_window_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_addr[ADDR_W-1:WIN_BITS] != WTAG) |=> $stable(obs_all));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_stb |=> $stable(obs_all));

  // R12
  text_set_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_addr == {WTAG, 7'h51}) |=> text_mode);

  // R4
  wr_only_pairs_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_rw) |=> $stable({store80, aux_wr, aux_zp, col80, alt_charset}));

  // R6
  iodis_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!cls_enh || bus_rw || !bus_stb) |=> !$rose(io_disable));

  // R8
  colour_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_stb && !bus_rw && cls_ext) |=> $stable({tb_colour, border_colour}));

endmodule

// File: tb/sswitch_shadow_tb_top.sv
module sswitch_shadow_tb_top;

  localparam int VW = 12 + 8 + 7 + 8 + 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_stb = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_rw = 1'b1;
  logic        cls_enh = 1'b0;
  logic        cls_ext = 1'b0;

  logic text_mode, mixed_mode, page2_sel, hires_mode, store80, aux_wr, aux_zp;
  logic col80, alt_charset, dbl_lores, io_disable, mono_mode;
  logic [7:0] nvid_ctl, tb_colour;
  logic [6:0] shadow_ctl;
  logic [3:0] border_colour;

  always #5 clk = ~clk;

  sswitch_shadow dut_i (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_rw(bus_rw), .cls_enh(cls_enh), .cls_ext(cls_ext),
    .text_mode(text_mode), .mixed_mode(mixed_mode), .page2_sel(page2_sel),
    .hires_mode(hires_mode), .store80(store80), .aux_wr(aux_wr), .aux_zp(aux_zp),
    .col80(col80), .alt_charset(alt_charset), .dbl_lores(dbl_lores),
    .io_disable(io_disable), .mono_mode(mono_mode), .nvid_ctl(nvid_ctl),
    .shadow_ctl(shadow_ctl), .tb_colour(tb_colour), .border_colour(border_colour)
  );

  logic [VW-1:0] act_vec;
  assign act_vec = {text_mode, mixed_mode, page2_sel, hires_mode, store80, aux_wr,
                    aux_zp, col80, alt_charset, dbl_lores, io_disable, mono_mode,
                    nvid_ctl, shadow_ctl, tb_colour, border_colour};

  // reference state, kept from the requirements
  logic [11:0] m_sw;   // same bit order as the top of act_vec
  logic [7:0]  m_nvid, m_tb;
  logic [6:0]  m_shad;
  logic [3:0]  m_bd;

  typedef struct {
    logic [VW-1:0] v;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  function automatic logic [VW-1:0] model_vec();
    return {m_sw, m_nvid, m_shad, m_tb, m_bd};
  endfunction

  // m_sw bit positions: 11 text .. 0 mono
  task automatic model_step(input logic s, input logic [15:0] a, input logic [7:0] d,
                            input logic r, input logic e, input logic x);
    logic win, wr, ei;
    logic [6:0] o;
    win = s && (a[15:7] == 9'h180);
    wr  = !r;
    ei  = e | x;
    o   = a[6:0];
    if (win) begin
      case (o)
        7'h50: m_sw[11] = 1'b0;  7'h51: m_sw[11] = 1'b1;
        7'h52: m_sw[10] = 1'b0;  7'h53: m_sw[10] = 1'b1;
        7'h54: m_sw[9]  = 1'b0;  7'h55: m_sw[9]  = 1'b1;
        7'h56: m_sw[8]  = 1'b0;  7'h57: m_sw[8]  = 1'b1;
        7'h00, 7'h01: if (wr && ei) m_sw[7] = o[0];
        7'h04, 7'h05: if (wr && ei) m_sw[6] = o[0];
        7'h08, 7'h09: if (wr && ei) m_sw[5] = o[0];
        7'h0C, 7'h0D: if (wr && ei) m_sw[4] = o[0];
        7'h0E, 7'h0F: if (wr && ei) m_sw[3] = o[0];
        7'h5E, 7'h5F: if (ei) m_sw[2] = !o[0];
        7'h7E, 7'h7F: if (wr && e) m_sw[1] = !o[0];
        7'h21: if (wr && ei) m_sw[0] = d[7];
        7'h22: if (wr && x) m_tb = d;
        7'h34: if (wr && x) m_bd = d[3:0];
        7'h29: if (wr && x) m_nvid = d;
        7'h35: if (wr && x) m_shad = d[6:0];
        default: ;
      endcase
    end
  endtask

  // driver: one bus cycle, then push the expected outputs
  task automatic cyc(input logic s, input logic [15:0] a, input logic [7:0] d,
                     input logic r, input logic e, input logic x, input string tag);
    @(negedge clk);
    bus_stb = s; bus_addr = a; bus_data = d; bus_rw = r; cls_enh = e; cls_ext = x;
    @(posedge clk);
    model_step(s, a, d, r, e, x);
    exp_q.push_back('{model_vec(), tag});
  endtask

  // monitor: compare one cycle after each sampled edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      n_checks++;
      if (act_vec !== it.v) begin
        n_fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act_vec, it.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    m_sw = '0; m_nvid = '0; m_tb = '0; m_shad = '0; m_bd = '0;
    repeat (3) @(posedge clk);
    exp_q.push_back('{model_vec(), "R1 reset"});
    @(negedge clk);
    rst = 1'b0;

    // R3 / R12: display pairs on reads and writes, no class
    cyc(1, 16'hC051, 8'h00, 1, 0, 0, "R12 R3 text set by read");
    cyc(1, 16'hC053, 8'h00, 0, 0, 0, "R3 mixed set by write");
    cyc(1, 16'hC055, 8'h00, 1, 0, 0, "R3 page2 set");
    cyc(1, 16'hC057, 8'h00, 1, 0, 0, "R3 hires set");
    cyc(1, 16'hC050, 8'h00, 0, 0, 0, "R3 text clear");
    cyc(1, 16'hC054, 8'h00, 1, 0, 0, "R3 page2 clear");

    // R4: write-only pairs gated by class
    cyc(1, 16'hC001, 8'h00, 0, 0, 0, "R4 80store no class ignored");
    cyc(1, 16'hC001, 8'h00, 1, 1, 0, "R4 80store read ignored");
    cyc(1, 16'hC001, 8'h00, 0, 1, 0, "R4 80store set");
    cyc(1, 16'hC005, 8'h00, 0, 0, 1, "R4 auxwr set ext");
    cyc(1, 16'hC009, 8'h00, 0, 1, 0, "R4 auxzp set");
    cyc(1, 16'hC00D, 8'h00, 0, 1, 0, "R4 col80 set");
    cyc(1, 16'hC00F, 8'h00, 0, 1, 0, "R4 altchr set");
    cyc(1, 16'hC00C, 8'h00, 0, 1, 0, "R4 col80 clear");
    cyc(1, 16'hC000, 8'h00, 1, 1, 1, "R4 80store clear by read ignored");

    // R5: double-low-res
    cyc(1, 16'hC05E, 8'h00, 1, 0, 0, "R5 dlr no class ignored");
    cyc(1, 16'hC05E, 8'h00, 1, 0, 1, "R5 dlr set by read");
    cyc(1, 16'hC05F, 8'h00, 0, 1, 0, "R5 dlr clear by write");

    // R6: I/O disable
    cyc(1, 16'hC07E, 8'h00, 0, 0, 1, "R6 iodis ext only ignored");
    cyc(1, 16'hC07E, 8'h00, 0, 1, 0, "R6 iodis set");
    cyc(1, 16'hC07F, 8'h00, 1, 1, 0, "R6 iodis read ignored");
    cyc(1, 16'hC07F, 8'h00, 0, 1, 0, "R6 iodis clear");

    // R7: monochrome from data bit 7
    cyc(1, 16'hC021, 8'h80, 0, 0, 0, "R7 mono no class ignored");
    cyc(1, 16'hC021, 8'h80, 0, 0, 1, "R7 mono set");
    cyc(1, 16'hC021, 8'h7F, 0, 1, 0, "R7 mono clear");

    // R8 / R9: colour registers
    cyc(1, 16'hC022, 8'hA5, 0, 1, 0, "R8 tb enh only ignored");
    cyc(1, 16'hC022, 8'hA5, 0, 0, 1, "R8 tb load");
    cyc(1, 16'hC022, 8'h3C, 1, 0, 1, "R8 tb read ignored");
    cyc(1, 16'hC034, 8'hF7, 0, 0, 1, "R9 border low nibble");

    // R10: masked fields
    cyc(1, 16'hC029, 8'hC3, 0, 0, 1, "R10 nvid load");
    cyc(1, 16'hC035, 8'hFF, 0, 0, 1, "R10 shadow low 7 bits");
    cyc(1, 16'hC035, 8'h12, 0, 1, 0, "R10 shadow enh only ignored");

    // R2: outside the window
    cyc(1, 16'hC151, 8'h00, 1, 1, 1, "R2 alias above ignored");
    cyc(1, 16'h4050, 8'h00, 0, 1, 1, "R2 alias low ignored");
    cyc(1, 16'hC1A2, 8'h55, 0, 1, 1, "R2 alias tb ignored");

    // R11: no strobe, unlisted offsets
    cyc(0, 16'hC051, 8'h00, 1, 1, 1, "R11 no strobe ignored");
    cyc(0, 16'hC022, 8'h11, 0, 1, 1, "R11 no strobe write ignored");
    cyc(1, 16'hC010, 8'hFF, 0, 1, 1, "R11 unlisted offset ignored");
    cyc(1, 16'hC03F, 8'hFF, 0, 1, 1, "R11 unlisted offset 3F ignored");

    cyc(0, 16'h0000, 8'h00, 1, 0, 0, "R11 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule